// File: doc/BRIEF.md
# Burst Gain Ramp Controller

This block shapes the start and end of a transmitted burst. It holds a programmable amplitude envelope in a 128-word gain memory. It scales every sample of a data stream by the word that a ramp pointer currently selects.

When transmit enable goes high, the pointer climbs one entry per coarse-phase step until it reaches the programmed length. When transmit enable goes low, the pointer walks back down to entry zero, so the fade-out mirrors the fade-in. If transmit enable reverses partway through a ramp, the pointer turns around from wherever it is.

Gain words are unsigned fractions, and 0x800 stands for unity. With the profile switched off, the block passes samples through at unity gain. A hold control freezes the pointer and the applied gain, so the memory can be rewritten while the channel stays live. A bypass control skips the memory altogether and gates the stream directly with transmit enable.

Top module: `burst_gain_ramp`

## Requirements
- R1: A cycle with `wr_en` high stores `wr_data` (12 bits) at entry `wr_addr` (7 bits, entries 0 to 127). Later ramps apply the stored word.
- R2: Gain words are unsigned with 11 fraction bits: 0x800 is 1.0, 0x001 is 2^-11 and 0x000 is 0.0. `sample_out` is (signed `sample_in` × gain) shifted right arithmetically by 11 and truncated to the sample width. It is registered, so it appears one clock after the applied gain and sample are present.
- R3: While `prof_en` is low, the pointer is forced to entry 0. If `hold` is also low, the applied gain becomes 0x800, so `sample_out` equals `sample_in` one clock later.
- R4: With `prof_en` high and `txen` high, each step moves the pointer one entry toward `prof_len`. The pointer stops when it equals `prof_len`.
- R5: With `prof_en` high and `txen` low, each step lowers the pointer by one until it reaches 0, where it stays.
- R6: A change of `txen` in the middle of a ramp reverses direction from the current pointer value, with no jump.
- R7: The pointer moves only on clocks where `step_en` is high. All other clocks leave it unchanged.
- R8: While `hold` is high, the pointer and the applied gain are frozen. Memory writes made during hold do not change `sample_out` until hold is released.
- R9: With `prof_en` high and `bypass` high, the applied gain is 0x800 when `txen` is high and 0x000 when it is low. The memory is ignored.
- R10: The applied gain is loaded one clock after the pointer takes a new value. `sample_out` is 0 while reset is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one sample per cycle |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| step_en | input | 1 | Coarse-phase step strobe for the pointer |
| txen | input | 1 | Transmit enable; a high level ramps up, a low level ramps down |
| prof_en | input | 1 | Envelope enable; when low, the pointer is cleared and gain is unity |
| hold | input | 1 | Freezes the pointer and the applied gain |
| bypass | input | 1 | Gates the stream with txen instead of the memory |
| prof_len | input | 7 | Top entry of the ramp |
| wr_en | input | 1 | Gain memory write strobe |
| wr_addr | input | 7 | Gain memory write address |
| wr_data | input | 12 | Gain word to write |
| sample_in | input | 16 | Signed input sample |
| sample_out | output | 16 | Signed scaled output sample |

## Verification
The envelope is loaded with an odd-stepped ramp. It is then driven with full rises and falls at two step rates, which separates a pointer that tracks `step_en` from one that runs freely. A rise cut off after a few steps and followed by a fall shows whether the pointer reverses in place or resets. A hold window with memory writes aimed at the frozen entry, and a bypass pass with `txen` toggling, separate gain taken from the memory from gain taken from the control inputs. Random signed samples, including negative ones, expose errors in truncation and arithmetic shifting against the reference model, which is compared on every clock.

// File: rtl/burst_gain_pkg.sv
package burst_gain_pkg;
  typedef enum logic [1:0] {
    MV_STAY = 2'd0,
    MV_UP   = 2'd1,
    MV_DOWN = 2'd2
  } ptr_move_e;

  function automatic logic [31:0] unity_word(input int gain_w);
    return 32'd1 << (gain_w - 1);
  endfunction
endpackage

// File: rtl/gain_ptr_ctrl.sv
module gain_ptr_ctrl
  import burst_gain_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prof_en,
  input  logic              txen,
  input  logic              step_en,
  input  logic              hold,
  input  logic [ADDR_W-1:0] len,
  output logic [ADDR_W-1:0] ptr
);
  ptr_move_e         move;
  logic [ADDR_W-1:0] ptr_d;

  always_comb begin
    move = MV_STAY;
    if (step_en && !hold) begin
      if (txen) begin
        if (ptr < len)      move = MV_UP;
        else if (ptr > len) move = MV_DOWN;
      end else if (ptr != '0) begin
        move = MV_DOWN;
      end
    end
  end

  always_comb begin
    if (!prof_en)             ptr_d = '0;
    else if (move == MV_UP)   ptr_d = ptr + 1'b1;
    else if (move == MV_DOWN) ptr_d = ptr - 1'b1;
    else                      ptr_d = ptr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr <= '0;
    else        ptr <= ptr_d;
  end

  assert_ptr_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !prof_en |=> ptr == '0);
  assert_ptr_unit_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    prof_en |=> (ptr == $past(ptr) || ptr == $past(ptr) + 1'b1 || ptr == $past(ptr) - 1'b1));
  assert_ptr_stop_at_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    prof_en && txen && ptr == len |=> $stable(ptr));
  assert_ptr_floor_R5: assert property (@(posedge clk) disable iff (!rst_n)
    prof_en && !txen && ptr == '0 |=> ptr == '0);
  assert_ptr_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    prof_en && (!step_en || hold) |=> $stable(ptr));
endmodule

// File: rtl/gain_ram.sv
module gain_ram #(
  parameter int ADDR_W = 7,
  parameter int GAIN_W = 12
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [GAIN_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [GAIN_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [GAIN_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/gain_apply.sv
module gain_apply #(
  parameter int DATA_W = 16,
  parameter int GAIN_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] sample_in,
  input  logic [GAIN_W-1:0] gain,
  output logic [DATA_W-1:0] sample_out
);
  localparam int PROD_W = DATA_W + GAIN_W + 1;
  localparam int FRAC_W = GAIN_W - 1;
  localparam logic [GAIN_W-1:0] UNITY = GAIN_W'(burst_gain_pkg::unity_word(GAIN_W));

  logic signed [PROD_W-1:0] prod;
  logic signed [PROD_W-1:0] scaled;
  logic [DATA_W-1:0]        out_d;

  always_comb begin
    prod   = $signed(sample_in) * $signed({1'b0, gain});
    scaled = prod >>> FRAC_W;
    out_d  = scaled[DATA_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sample_out <= '0;
    else        sample_out <= out_d;
  end

  assert_unity_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    gain == UNITY |=> sample_out == $past(sample_in));
  assert_zero_gain_R2: assert property (@(posedge clk) disable iff (!rst_n)
    gain == '0 |=> sample_out == '0);
endmodule

// File: rtl/burst_gain_ramp.sv
module burst_gain_ramp #(
  parameter int DATA_W = 16,
  parameter int GAIN_W = 12,
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_en,
  input  logic              txen,
  input  logic              prof_en,
  input  logic              hold,
  input  logic              bypass,
  input  logic [ADDR_W-1:0] prof_len,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [GAIN_W-1:0] wr_data,
  input  logic [DATA_W-1:0] sample_in,
  output logic [DATA_W-1:0] sample_out
);
  localparam logic [GAIN_W-1:0] UNITY = GAIN_W'(burst_gain_pkg::unity_word(GAIN_W));

  logic [1:0]        rst_sync;
  logic              core_rst_n;
  logic [ADDR_W-1:0] ptr;
  logic [GAIN_W-1:0] ram_word;
  logic [GAIN_W-1:0] gain_q;
  logic [GAIN_W-1:0] gain_d;
  logic              gain_ce;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign core_rst_n = rst_sync[1];

  gain_ptr_ctrl #(.ADDR_W(ADDR_W)) u_ptr (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .prof_en (prof_en),
    .txen    (txen),
    .step_en (step_en),
    .hold    (hold),
    .len     (prof_len),
    .ptr     (ptr)
  );

  gain_ram #(.ADDR_W(ADDR_W), .GAIN_W(GAIN_W)) u_ram (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (ptr),
    .rd_data (ram_word)
  );

  assign gain_ce = !hold;

  always_comb begin
    if (!prof_en)    gain_d = UNITY;
    else if (bypass) gain_d = txen ? UNITY : '0;
    else             gain_d = ram_word;
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n)  gain_q <= '0;
    else if (gain_ce) gain_q <= gain_d;
  end

  gain_apply #(.DATA_W(DATA_W), .GAIN_W(GAIN_W)) u_apply (
    .clk        (clk),
    .rst_n      (core_rst_n),
    .sample_in  (sample_in),
    .gain       (gain_q),
    .sample_out (sample_out)
  );

  assert_gain_frozen_R8: assert property (@(posedge clk) disable iff (!core_rst_n)
    hold |=> $stable(gain_q));
  assert_bypass_gate_R9: assert property (@(posedge clk) disable iff (!core_rst_n)
    prof_en && bypass && !hold |=> gain_q == ($past(txen) ? UNITY : '0));
  assert_unity_when_off_R3: assert property (@(posedge clk) disable iff (!core_rst_n)
    !prof_en && !hold |=> gain_q == UNITY);
  assert_gain_follows_ptr_R10: assert property (@(posedge clk) disable iff (!core_rst_n)
    prof_en && !bypass && !hold && !wr_en |=> gain_q == $past(ram_word));
  assert_reset_out_R10: assert property (@(posedge clk)
    !rst_n |-> sample_out == '0);
endmodule

// File: tb/burst_gain_ramp_test.sv
module burst_gain_ramp_test;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int GW = 12;
  localparam int AW = 7;

  logic          clk;
  logic          rst_n;
  logic          step_en, txen, prof_en, hold, bypass, wr_en;
  logic [AW-1:0] prof_len, wr_addr;
  logic [GW-1:0] wr_data;
  logic [DW-1:0] sample_in;
  logic [DW-1:0] sample_out;

  int    n_tests, n_fail;
  bit    model_on, done;
  string cur_req;

  int m_ram [128];
  int m_ptr, m_gain;
  logic [DW-1:0] m_out;

  burst_gain_ramp uut (
    .clk(clk), .rst_n(rst_n), .step_en(step_en), .txen(txen), .prof_en(prof_en),
    .hold(hold), .bypass(bypass), .prof_len(prof_len), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .sample_in(sample_in), .sample_out(sample_out)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: sample_out=%h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // Reference model: one update per rising edge, from pre-edge values
  always @(posedge clk) begin
    if (model_on) begin
      int n_gain, n_ptr;
      longint prod;
      prod  = longint'($signed(sample_in)) * longint'(m_gain);
      prod  = prod >>> 11;
      m_out = prod[DW-1:0];
      if (hold)          n_gain = m_gain;
      else if (!prof_en) n_gain = 2048;
      else if (bypass)   n_gain = txen ? 2048 : 0;
      else               n_gain = m_ram[m_ptr];
      n_ptr = m_ptr;
      if (!prof_en) n_ptr = 0;
      else if (step_en && !hold) begin
        if (txen) begin
          if (m_ptr < int'(prof_len))      n_ptr = m_ptr + 1;
          else if (m_ptr > int'(prof_len)) n_ptr = m_ptr - 1;
        end else if (m_ptr > 0) n_ptr = m_ptr - 1;
      end
      if (wr_en) m_ram[wr_addr] = int'(wr_data);
      m_gain = n_gain;
      m_ptr  = n_ptr;
    end
  end

  always @(negedge clk) begin
    if (model_on && !done) check(cur_req, sample_out, m_out);
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  task automatic run(input int n, input int step_div);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sample_in = DW'($urandom);
      step_en   = (step_div > 0) && ((i % step_div) == 0);
    end
  endtask

  task automatic write_word(input int addr, input int val);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_addr = AW'(addr);
    wr_data = GW'(val);
    sample_in = DW'($urandom);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    n_tests = 0; n_fail = 0; model_on = 0; done = 0;
    cur_req = "R10";
    step_en = 0; txen = 0; prof_en = 0; hold = 0; bypass = 0; wr_en = 0;
    prof_len = '0; wr_addr = '0; wr_data = '0; sample_in = '0;
    for (int i = 0; i < 128; i++) m_ram[i] = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    sample_in = 16'h1234;
    @(negedge clk);
    check("R10 reset", sample_out, '0);
    rst_n = 1;
    sample_in = '0;
    repeat (5) @(negedge clk);
    m_ptr = 0; m_gain = 2048; m_out = '0;
    model_on = 1;

    cur_req = "R3 unity pass";
    run(40, 1);

    cur_req = "R1 memory load";
    for (int i = 0; i < 64; i++) write_word(i, (i <= 32) ? (i * 64 + (i % 2) * 5) : 2048 - i);

    cur_req = "R4 ramp up";
    prof_len = 7'd20; prof_en = 1; txen = 1;
    run(100, 3);
    cur_req = "R5 ramp down";
    txen = 0;
    run(100, 3);

    cur_req = "R7 fast step rise";
    prof_len = 7'd32; txen = 1;
    run(50, 1);
    cur_req = "R2 full gain";
    run(20, 1);
    cur_req = "R5 fast fall";
    txen = 0;
    run(50, 1);

    cur_req = "R6 reversal";
    txen = 1;
    run(24, 2);
    txen = 0;
    run(10, 2);
    txen = 1;
    run(16, 2);
    txen = 0;
    run(80, 2);

    cur_req = "R7 no step";
    txen = 1;
    run(30, 0);
    txen = 0;
    run(10, 0);
    txen = 1;
    run(20, 1);

    cur_req = "R8 hold";
    hold = 1;
    write_word(20, 100);
    write_word(21, 300);
    write_word(19, 7);
    run(20, 1);
    hold = 0;
    cur_req = "R8 after hold";
    run(20, 1);
    txen = 0;
    run(60, 1);

    cur_req = "R9 bypass";
    bypass = 1;
    run(10, 1);
    txen = 1;
    run(10, 1);
    txen = 0;
    run(6, 1);
    txen = 1;
    run(6, 1);
    bypass = 0;
    cur_req = "R4 length lowered";
    prof_len = 7'd10;
    run(40, 1);

    cur_req = "R3 profile off";
    prof_en = 0;
    run(20, 1);

    model_on = 0;
    finish_run();
  end
endmodule